// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a linear framebuffer in memory and emits the read requests needed to fetch one frame, line by line. Each line starts at a byte address, is fetched as a run of fixed-size bursts, and the next line begins one pitch further on. Pitch and fetched length are programmed separately, so a line may be shorter than its stride in memory, or longer than it when lines overlap. The output is a request address plus a beat count, held until the memory side accepts it.

A start-of-frame pulse samples the whole configuration: the frame base, the bytes per line, the pitch, the line count, the burst size and the cap on outstanding requests. The block then fetches the frame and goes quiet until the next pulse. Every accepted request counts as in flight until the memory side returns a completion pulse. While the in-flight count sits at the cap, no new request is raised. A beat is a fixed number of bytes (parameter `BEAT_BYTES`, 8 by default).

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset `req_valid` and `busy` are low, and no request is raised until `frame_start` is pulsed. This also holds after a reset in the middle of a frame.
- R2: `frame_start` samples every `cfg_*` input. The first request of the frame carries the sampled base. Configuration changes made after the pulse have no effect until the next pulse.
- R3: Within a line, each request address equals the previous one plus the previous burst's beat count times `BEAT_BYTES`.
- R4: The line length in beats is `cfg_line_bytes / BEAT_BYTES`, and `cfg_line_bytes` must be a multiple of `BEAT_BYTES`. Each burst carries the smaller of the effective burst size and the beats still to fetch in the line, so the last burst of a line is shortened and nothing past the line is requested. `req_beats` is always between 1 and `MAX_BURST`.
- R5: A `cfg_burst` value from 1 to `MAX_BURST` is the burst size in beats. The values 0 and anything above `MAX_BURST` both mean `MAX_BURST`.
- R6: The first request of each line after the first is at the previous line's start address plus `cfg_pitch`.
- R7: `cfg_line_last` is the number of lines minus one. After the last burst of the last line is accepted, no further request is raised and `busy` falls until the next `frame_start`.
- R8: Outstanding requests are those accepted and not yet completed by a `burst_done` pulse. `req_valid` is never high while the outstanding count equals `cfg_max_out`, which must be from 1 to `MAX_OUT`. A `burst_done` pulse frees one slot, and a `burst_done` pulse with nothing outstanding is ignored.
- R9: A raised request keeps `req_valid`, `req_addr` and `req_beats` stable until it is accepted (`req_valid` and `req_ack` high at a clock edge).
- R10: A `frame_start` pulse while a frame is in progress drops any unaccepted request, and the next request is at the new base.
- R11: A line length of zero bytes makes the frame fetch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start-of-frame pulse; samples configuration and restarts |
| cfg_base | input | ADDR_W | Byte address of the first pixel of the frame |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Byte step between successive line starts |
| cfg_line_last | input | LINES_W | Number of lines minus one |
| cfg_burst | input | BURST_W | Burst size in beats (0 or too large means MAX_BURST) |
| cfg_max_out | input | OUT_W | Cap on outstanding requests |
| req_ack | input | 1 | Memory side accepts the current request |
| burst_done | input | 1 | One outstanding burst has completed |
| req_valid | output | 1 | A request is presented |
| req_addr | output | ADDR_W | Byte address of the requested burst |
| req_beats | output | BURST_W | Beats in the requested burst |
| busy | output | 1 | Frame fetch in progress or request pending |

## Verification
The checker relies on the memory side never raising `burst_done` without a request in flight, and on `cfg_max_out` being at least one. Its own in-flight count would otherwise drift from the block's, or the cap would stall every frame. The bench keeps within both rules: it completes bursts only from its own count of accepted requests, and every stimulus vector programs a cap from 1 to 8. Line lengths in the vectors are always whole beats, as R4 requires.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Map a programmed burst field onto a usable beat count.
  function automatic int unsigned burst_limit(input int unsigned sel, input int unsigned cap);
    return (sel == 0 || sel > cap) ? cap : sel;
  endfunction

endpackage

// File: rtl/fb_scan_cursor.sv
module fb_scan_cursor #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINES_W    = 12,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  parameter int BURST_W    = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base,
  input  logic [LEN_W-1:0]   line_bytes,
  input  logic [LEN_W-1:0]   pitch,
  input  logic [LINES_W-1:0] line_last,
  input  logic [BURST_W-1:0] burst_sel,
  input  logic               advance,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [BURST_W-1:0] cur_beats,
  output logic               active
);
  import fb_scan_pkg::*;

  localparam int BEAT_SH = $clog2(BEAT_BYTES);

  scan_state_e        state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  line_base_q;
  logic [LEN_W-1:0]   rem_q;
  logic [LINES_W-1:0] idx_q;
  logic [LEN_W-1:0]   pitch_q;
  logic [LEN_W-1:0]   lbeats_q;
  logic [LINES_W-1:0] last_q;
  logic [BURST_W-1:0] burst_q;

  logic [LEN_W-1:0]   lbeats_in;
  logic [BURST_W-1:0] burst_in;
  logic [BURST_W-1:0] beats_now;
  logic               line_end;
  logic [ADDR_W-1:0]  step_bytes;
  logic [ADDR_W-1:0]  next_line;

  always_comb begin
    lbeats_in  = LEN_W'(line_bytes >> BEAT_SH);
    burst_in   = BURST_W'(burst_limit(int'(burst_sel), MAX_BURST));
    if (rem_q < LEN_W'(burst_q)) begin
      beats_now = BURST_W'(rem_q);
    end else begin
      beats_now = burst_q;
    end
    line_end   = (rem_q == LEN_W'(beats_now));
    step_bytes = ADDR_W'(beats_now) << BEAT_SH;
    next_line  = line_base_q + ADDR_W'(pitch_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SCAN_IDLE;
      addr_q      <= '0;
      line_base_q <= '0;
      rem_q       <= '0;
      idx_q       <= '0;
      pitch_q     <= '0;
      lbeats_q    <= '0;
      last_q      <= '0;
      burst_q     <= BURST_W'(MAX_BURST);
    end else if (start) begin
      addr_q      <= base;
      line_base_q <= base;
      rem_q       <= lbeats_in;
      idx_q       <= '0;
      pitch_q     <= pitch;
      lbeats_q    <= lbeats_in;
      last_q      <= line_last;
      burst_q     <= burst_in;
      state_q     <= (lbeats_in != '0) ? SCAN_RUN : SCAN_IDLE;
    end else if (advance && state_q == SCAN_RUN) begin
      if (line_end) begin
        if (idx_q == last_q) begin
          state_q <= SCAN_IDLE;
        end else begin
          idx_q       <= idx_q + 1'b1;
          line_base_q <= next_line;
          addr_q      <= next_line;
          rem_q       <= lbeats_q;
        end
      end else begin
        addr_q <= addr_q + step_bytes;
        rem_q  <= rem_q - LEN_W'(beats_now);
      end
    end
  end

  assign cur_addr  = addr_q;
  assign cur_beats = beats_now;
  assign active    = (state_q == SCAN_RUN);

endmodule

// File: rtl/fb_scan_credit.sv
module fb_scan_credit #(
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OUT_W-1:0] limit,
  input  logic             issue,
  input  logic             retire,
  output logic             room
);
  logic [OUT_W-1:0] cnt_q;
  logic [OUT_W-1:0] lim_q;
  logic             dec;

  assign dec = retire && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (start) begin
        lim_q <= limit;
      end
      case ({issue, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign room = (cnt_q < lim_q);

endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINES_W    = 12,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  parameter int MAX_OUT    = 8,
  parameter int BURST_W    = $clog2(MAX_BURST + 1),
  parameter int OUT_W      = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_bytes,
  input  logic [LEN_W-1:0]   cfg_pitch,
  input  logic [LINES_W-1:0] cfg_line_last,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [OUT_W-1:0]   cfg_max_out,
  input  logic               req_ack,
  input  logic               burst_done,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  output logic               busy
);
  logic               cur_active;
  logic               have_room;
  logic               issue;
  logic [ADDR_W-1:0]  cur_addr;
  logic [BURST_W-1:0] cur_beats;

  assign issue = req_valid && req_ack;

  fb_scan_cursor #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .LINES_W   (LINES_W),
    .BEAT_BYTES(BEAT_BYTES),
    .MAX_BURST (MAX_BURST),
    .BURST_W   (BURST_W)
  ) u_cursor (
    .clk       (clk),
    .rst       (rst),
    .start     (frame_start),
    .base      (cfg_base),
    .line_bytes(cfg_line_bytes),
    .pitch     (cfg_pitch),
    .line_last (cfg_line_last),
    .burst_sel (cfg_burst),
    .advance   (issue),
    .cur_addr  (cur_addr),
    .cur_beats (cur_beats),
    .active    (cur_active)
  );

  fb_scan_credit #(
    .OUT_W(OUT_W)
  ) u_credit (
    .clk   (clk),
    .rst   (rst),
    .start (frame_start),
    .limit (cfg_max_out),
    .issue (issue),
    .retire(burst_done),
    .room  (have_room)
  );

  // Request register: one request at a time, a bubble after each acceptance
  // lets the cursor and credit count settle before the next one is raised.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_beats <= '0;
    end else if (frame_start || issue) begin
      req_valid <= 1'b0;
    end else if (!req_valid && cur_active && have_room) begin
      req_valid <= 1'b1;
      req_addr  <= cur_addr;
      req_beats <= cur_beats;
    end
  end

  assign busy = cur_active || req_valid;

endmodule

// File: rtl/fb_scan_chk.sv
module fb_scan_chk #(
  parameter int ADDR_W    = 32,
  parameter int BURST_W   = 5,
  parameter int OUT_W     = 4,
  parameter int MAX_BURST = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic [OUT_W-1:0]   cfg_max_out,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BURST_W-1:0] req_beats,
  input logic               req_ack,
  input logic               burst_done
);
  logic [OUT_W:0]   ck_cnt;
  logic [OUT_W-1:0] ck_lim;
  logic             seen_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_cnt     <= '0;
      ck_lim     <= '0;
      seen_start <= 1'b0;
    end else begin
      if (frame_start) begin
        ck_lim     <= cfg_max_out;
        seen_start <= 1'b1;
      end
      if ((req_valid && req_ack) && !(burst_done && ck_cnt != '0)) begin
        ck_cnt <= ck_cnt + 1'b1;
      end else if (!(req_valid && req_ack) && burst_done && ck_cnt != '0) begin
        ck_cnt <= ck_cnt - 1'b1;
      end
    end
  end

  // R1
  idle_before_start_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_start |-> !req_valid);

  // R4
  beats_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_beats != '0 && req_beats <= BURST_W'(MAX_BURST)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (ck_cnt < {1'b0, ck_lim}));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_beats)));

  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !req_valid);

endmodule

bind fb_scan_addr_gen fb_scan_chk #(
  .ADDR_W   (ADDR_W),
  .BURST_W  (BURST_W),
  .OUT_W    (OUT_W),
  .MAX_BURST(MAX_BURST)
) u_chk (.*);

// File: tb/fb_scan_addr_gen_test.sv
module fb_scan_addr_gen_test;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int LINES_W = 12;
  localparam int BURST_W = 5;
  localparam int OUT_W  = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               frame_start = 1'b0;
  logic [ADDR_W-1:0]  cfg_base = '0;
  logic [LEN_W-1:0]   cfg_line_bytes = '0;
  logic [LEN_W-1:0]   cfg_pitch = '0;
  logic [LINES_W-1:0] cfg_line_last = '0;
  logic [BURST_W-1:0] cfg_burst = '0;
  logic [OUT_W-1:0]   cfg_max_out = '0;
  logic               req_ack = 1'b0;
  logic               burst_done = 1'b0;
  logic               req_valid;
  logic [ADDR_W-1:0]  req_addr;
  logic [BURST_W-1:0] req_beats;
  logic               busy;

  always #4 clk = ~clk;

  fb_scan_addr_gen uut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_line_last(cfg_line_last), .cfg_burst(cfg_burst), .cfg_max_out(cfg_max_out),
    .req_ack(req_ack), .burst_done(burst_done),
    .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats), .busy(busy)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [15:0] pitch;
    logic [11:0] lastl;
    logic [4:0]  burst;
    logic [3:0]  maxo;
    logic [3:0]  ackg;
    logic [3:0]  doneg;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'd128, 16'd128,  12'd3, 5'd16, 4'd4, 4'd1, 4'd2},
    '{32'h0000_2000, 16'd200, 16'd256,  12'd2, 5'd8,  4'd2, 4'd2, 4'd3},
    '{32'h0001_0000, 16'd320, 16'd512,  12'd1, 5'd0,  4'd8, 4'd1, 4'd1},
    '{32'h0000_3000, 16'd136, 16'd256,  12'd0, 5'd20, 4'd3, 4'd3, 4'd2},
    '{32'h0000_4000, 16'd64,  16'd96,   12'd4, 5'd4,  4'd1, 4'd1, 4'd7},
    '{32'h0000_5000, 16'd24,  16'd1000, 12'd2, 5'd1,  4'd5, 4'd2, 4'd4}
  };

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input vec_t v);
    cfg_base       = v.base;
    cfg_line_bytes = v.len;
    cfg_pitch      = v.pitch;
    cfg_line_last  = v.lastl;
    cfg_burst      = v.burst;
    cfg_max_out    = v.maxo;
  endtask

  task automatic run_frame(input vec_t v, input string tag);
    int eff, lbeats, e_line, e_rem, e_beats, bo, cd, got, extra, idle, exp_total;
    logic [31:0] e_addr, e_lb, p_addr;
    bit e_done, acc, dn, ovf, hold_bad, p_valid, p_acc, finished;
    eff       = (v.burst == 0 || v.burst > 16) ? 16 : int'(v.burst);
    lbeats    = int'(v.len) / 8;
    exp_total = (lbeats == 0) ? 0 : (int'(v.lastl) + 1) * ((lbeats + eff - 1) / eff);
    @(negedge clk);
    load_cfg(v);
    req_ack = 1'b0; burst_done = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    // R2: scramble the configuration after the pulse; the frame must not see it
    cfg_base = ~v.base; cfg_pitch = v.pitch + 16'd8; cfg_line_bytes = v.len + 16'd64;
    cfg_line_last = v.lastl + 12'd1; cfg_burst = 5'd2; cfg_max_out = 4'd8;
    e_line = 0; e_rem = lbeats; e_addr = v.base; e_lb = v.base; e_done = (lbeats == 0);
    bo = 0; cd = int'(v.doneg); got = 0; extra = 0; idle = 0;
    ovf = 0; hold_bad = 0; p_valid = 0; p_acc = 0; p_addr = '0; finished = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (e_done && bo == 0 && idle >= 20) begin
        finished = 1;
        break;
      end
      acc = 0;
      if (req_valid) begin
        if (bo >= int'(v.maxo)) ovf = 1;
        if (p_valid && !p_acc && req_addr != p_addr) hold_bad = 1;
        if ((cyc % int'(v.ackg)) == 0) acc = 1;
      end
      dn = (bo > 0 && cd == 0);
      req_ack = acc; burst_done = dn;
      if (acc) begin
        if (e_done) begin
          extra++;
        end else begin
          e_beats = (e_rem < eff) ? e_rem : eff;
          check(req_addr == e_addr, {"R2 R3 R6 ", tag}, "burst address", 64'(req_addr), 64'(e_addr));
          check(int'(req_beats) == e_beats, {"R4 R5 ", tag}, "burst beats", 64'(req_beats), 64'(e_beats));
          got++;
          if (e_rem == e_beats) begin
            if (e_line == int'(v.lastl)) begin
              e_done = 1;
            end else begin
              e_line++;
              e_lb = e_lb + 32'(v.pitch);
              e_addr = e_lb;
              e_rem = lbeats;
            end
          end else begin
            e_addr = e_addr + 32'(e_beats * 8);
            e_rem = e_rem - e_beats;
          end
        end
      end
      if (e_done && !req_valid && bo == 0) idle++; else idle = 0;
      p_valid = req_valid; p_acc = acc; p_addr = req_addr;
      @(negedge clk);
      bo = bo + (acc ? 1 : 0) - (dn ? 1 : 0);
      if (dn) cd = int'(v.doneg);
      else if (bo > 0 && cd > 0) cd--;
    end
    req_ack = 1'b0; burst_done = 1'b0;
    check(finished && extra == 0 && got == exp_total, {"R7 ", tag}, "bursts in frame",
          64'(got + extra), 64'(exp_total));
    check(!ovf, {"R8 ", tag}, "request raised at outstanding cap", 64'(ovf), 64'd0);
    check(!hold_bad, {"R9 ", tag}, "pending request changed", 64'(hold_bad), 64'd0);
    check(busy == 1'b0, {"R7 ", tag}, "busy after frame", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, nothing without a frame_start
    load_cfg(VECS[0]);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_valid || busy) seen = 1;
    end
    check(!seen, "R1", "activity before frame_start", 64'(seen), 64'd0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      run_frame(VECS[k], "table");
    end

    // R11: zero-length lines fetch nothing
    run_frame('{32'h0000_6000, 16'd0, 16'd128, 12'd3, 5'd8, 4'd4, 4'd1, 4'd1}, "R11");

    // R10: restart while a request is pending
    @(negedge clk);
    load_cfg(VECS[0]);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    check(seen && req_addr == VECS[0].base, "R10", "pending request before restart",
          64'(req_addr), 64'(VECS[0].base));
    run_frame(VECS[1], "R10");

    // R1: reset in the middle of a frame
    @(negedge clk);
    load_cfg(VECS[4]);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(req_valid == 1'b0 && busy == 1'b0, "R1", "outputs after mid-frame reset",
          64'({req_valid, busy}), 64'd0);
    rst = 1'b0;
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (req_valid || busy) seen = 1;
    end
    check(!seen, "R1", "activity after reset without frame_start", 64'(seen), 64'd0);

    // Fetch still works after the reset
    run_frame(VECS[3], "post-reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule